// File: doc/BRIEF.md
# Coprocessor Error Status and Interrupt Mask Registers

This block holds the host-visible error and status word of a coprocessor that serves commands out of a pool of 32 context descriptors. The command engine reports each error with a strobe. The report carries an 8-bit error code, the 5-bit index of the context that raised it, and a recoverable/fatal class. The descriptor store supplies a live count of free descriptors. The search table supplies a one-cycle pulse when it becomes full.

Several kinds of flag live side by side in the status word. The error class flags, the descriptors-full flag and the table-full flag are sticky and clear when the host reads the status word. The almost-full flag is not sticky: it follows the free-descriptor count. The code and context fields always show the latest error.

A 64-bit interrupt mask sits beside the status word. Only its lower half is implemented. The block drives one level interrupt whenever a status bit is set and its mask bit is clear. The host reaches both registers through a simple word-wide read/write port.

Top module: `cop_err_status`

## Requirements
- R1: After reset the status word reads 0, mask bits 31:0 read all ones, and `irq` is low.
- R2: On `err_valid`, the status word takes `err_code` into bits 7:0 and `err_ctx` into bits 12:8. Each later error overwrites both fields, and they hold between errors and across status reads.
- R3: An error with `err_recov`=1 sets bit 30. Codes 0 (invalid command) and 3 (invalid size field) are of this class. An error with `err_recov`=0 sets bit 31, as for code 4 (access timeout). Both bits hold until a status read clears them.
- R4: Bit 27 is high exactly when the `desc_free` value sampled at the previous clock edge is 2 or less. A status read does not clear it.
- R5: Bit 28 is set at a clock edge where `desc_free` is 0. It stays set until a status read at an edge where `desc_free` is nonzero.
- R6: A `tbl_full_evt` pulse sets bit 29, which holds until a status read clears it.
- R7: When a flag-setting event and a status read fall on the same clock edge, the flag ends up set. The data read shows the word as it was before that edge.
- R8: Address 0 is the status word, address 1 is mask bits 31:0, and address 2 is mask bits 63:32. Address 2 reads zero and ignores writes. Writes to address 0 are ignored. Status bits 26:13 read zero. `reg_rdata` is valid in the cycle after `reg_rd`.
- R9: `irq` is high in the cycle after any status bit is set while its mask bit is clear. It is low in the cycle after no such bit exists. A mask bit of 1 suppresses its status bit.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| err_valid | input | 1 | Error report strobe |
| err_recov | input | 1 | 1 = recoverable error, 0 = fatal error |
| err_code | input | 8 | Error code |
| err_ctx | input | 5 | Index of the offending context |
| desc_free | input | 6 | Number of free descriptors (0 to 32) |
| tbl_full_evt | input | 1 | Search-table full pulse |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt, active high |

## Verification
The assertions take some input properties for granted:
- `err_recov` matches the error code's class.
- `desc_free` never exceeds the descriptor count.
- `reg_rd` and `reg_wr` are never asserted together.

The stimulus keeps to all three. Each error vector pairs code 0 or 3 with the recoverable class and code 4 with the fatal class. The free count moves only between 0 and 10. Each read and each write gets a cycle of its own. The interrupt is checked only with mask values that leave exactly one status bit open or all bits closed.

// File: rtl/cop_err_status.sv
module cop_err_status #(
  parameter int CODE_W   = 8,
  parameter int CTX_W    = 5,
  parameter int NDESC    = 32,
  parameter int AF_FREE  = 2,
  parameter int DW       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          err_valid,
  input  logic                          err_recov,
  input  logic [CODE_W-1:0]             err_code,
  input  logic [CTX_W-1:0]              err_ctx,
  input  logic [$clog2(NDESC+1)-1:0]    desc_free,
  input  logic                          tbl_full_evt,
  input  logic                          reg_rd,
  input  logic                          reg_wr,
  input  logic [1:0]                    reg_addr,
  input  logic [DW-1:0]                 reg_wdata,
  output logic [DW-1:0]                 reg_rdata,
  output logic                          irq
);

  localparam int CNT_W = $clog2(NDESC+1);
  localparam int RSV_W = DW - 5 - CTX_W - CODE_W;
  localparam logic [CNT_W-1:0] AF_CNT = CNT_W'(AF_FREE);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MLO  = 2'd1;

  logic              fatal_q, recov_q, tfull_q, dfull_q, afull_q;
  logic [CTX_W-1:0]  ctx_q;
  logic [CODE_W-1:0] code_q;
  logic [DW-1:0]     mask_q;
  logic [DW-1:0]     status;
  logic              stat_rd;

  assign stat_rd = reg_rd && (reg_addr == A_STAT);
  assign status  = {fatal_q, recov_q, tfull_q, dfull_q, afull_q, {RSV_W{1'b0}}, ctx_q, code_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_q <= 1'b0;
      recov_q <= 1'b0;
      tfull_q <= 1'b0;
      dfull_q <= 1'b0;
      afull_q <= 1'b0;
      ctx_q   <= '0;
      code_q  <= '0;
    end else begin
      fatal_q <= (err_valid && !err_recov) || (fatal_q && !stat_rd);
      recov_q <= (err_valid &&  err_recov) || (recov_q && !stat_rd);
      tfull_q <= tbl_full_evt || (tfull_q && !stat_rd);
      dfull_q <= (desc_free == '0) || (dfull_q && !stat_rd);
      afull_q <= (desc_free <= AF_CNT);
      if (err_valid) begin
        ctx_q  <= err_ctx;
        code_q <= err_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MLO)
        mask_q <= reg_wdata;
      if (reg_rd) begin
        case (reg_addr)
          A_STAT:  reg_rdata <= status;
          A_MLO:   reg_rdata <= mask_q;
          default: reg_rdata <= '0;
        endcase
      end
      irq <= |(status & ~mask_q);
    end
  end

  assert_ctx_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (status[12:8] == $past(err_ctx)) && (status[7:0] == $past(err_code)));

  assert_fatal_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_recov) |=> status[31]);

  assert_recov_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_recov) |=> status[30]);

  assert_afull_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_free > AF_CNT) |=> !status[27]);

  assert_full_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_free == '0) |=> status[28]);

  assert_full_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && desc_free != '0) |=> !status[28]);

  assert_tfull_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full_evt |=> status[29]);

  assert_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |=> (reg_rdata == '0));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mask_q) == '0) |=> !irq);

endmodule

// File: tb/cop_err_status_bench.sv
module cop_err_status_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0, err_recov = 1'b0, tbl_full_evt = 1'b0;
  logic [7:0]  err_code = '0;
  logic [4:0]  err_ctx = '0;
  logic [5:0]  desc_free = 6'd10;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  cop_err_status u_cop_err_status (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_recov(err_recov),
    .err_code(err_code), .err_ctx(err_ctx), .desc_free(desc_free),
    .tbl_full_evt(tbl_full_evt), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        ev;
    logic        rc;
    logic [7:0]  code;
    logic [4:0]  ctx;
    logic [5:0]  fr;
    logic        tf;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 8'h00, 5'd3,  6'd10, 1'b0, 32'h4000_0300},
    '{1'b1, 1'b1, 8'h03, 5'd31, 6'd10, 1'b0, 32'h4000_1F03},
    '{1'b1, 1'b0, 8'h04, 5'd7,  6'd10, 1'b0, 32'h8000_0704},
    '{1'b0, 1'b0, 8'h00, 5'd0,  6'd0,  1'b0, 32'h1800_0704},
    '{1'b0, 1'b0, 8'h00, 5'd0,  6'd10, 1'b0, 32'h1000_0704},
    '{1'b0, 1'b0, 8'h00, 5'd0,  6'd2,  1'b0, 32'h0800_0704},
    '{1'b0, 1'b0, 8'h00, 5'd0,  6'd3,  1'b0, 32'h0000_0704},
    '{1'b0, 1'b0, 8'h00, 5'd0,  6'd10, 1'b1, 32'h2000_0704},
    '{1'b0, 1'b0, 8'h00, 5'd0,  6'd10, 1'b0, 32'h0000_0704},
    '{1'b1, 1'b1, 8'h00, 5'd0,  6'd1,  1'b1, 32'h6800_0000},
    '{1'b0, 1'b0, 8'h00, 5'd0,  6'd10, 1'b0, 32'h0000_0000}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a);
    reg_rd = 1'b1; reg_addr = a;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();

    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(2'd0); check("R1 status", reg_rdata, 32'h0);
    rd(2'd1); check("R1 mask", reg_rdata, 32'hFFFF_FFFF);

    // R2 R3 R4 R5 R6: one event cycle, then a status read
    for (int i = 0; i < NV; i++) begin
      err_valid = TBL[i].ev; err_recov = TBL[i].rc; err_code = TBL[i].code;
      err_ctx = TBL[i].ctx; desc_free = TBL[i].fr; tbl_full_evt = TBL[i].tf;
      step();
      err_valid = 1'b0; tbl_full_evt = 1'b0;
      rd(2'd0);
      check("R2 R3 R4 R5 R6 table", reg_rdata, TBL[i].exp);
    end

    // R7: fatal error and status read on the same edge
    err_valid = 1'b1; err_recov = 1'b0; err_code = 8'h04; err_ctx = 5'd9;
    reg_rd = 1'b1; reg_addr = 2'd0;
    step();
    err_valid = 1'b0; reg_rd = 1'b0;
    check("R7 old word", reg_rdata, 32'h0);
    rd(2'd0); check("R7 set kept", reg_rdata, 32'h8000_0904);

    // R9: open bit 30 only
    wr(2'd1, 32'hBFFF_FFFF);
    err_valid = 1'b1; err_recov = 1'b1; err_code = 8'h03; err_ctx = 5'd2;
    step();
    err_valid = 1'b0;
    check("R9 irq lag", {31'b0, irq}, 32'h0);
    step();
    check("R9 irq high", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF);
    step();
    check("R9 irq masked", {31'b0, irq}, 32'h0);

    // R8: register port
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2); check("R8 mask hi", reg_rdata, 32'h0);
    rd(2'd1); check("R8 mask lo", reg_rdata, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0); check("R8 status write ignored", reg_rdata, 32'h4000_0203);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule